// File: doc/BRIEF.md
# Completion-Triggered Buffer Scheduler

This block decides the order in which a compute unit works through its receive buffers. There is one buffer for each node that sends data. Each buffer has an arrival counter and a programmed target count. A buffer is complete when its counter reaches the target. Software lists the buffers it wants processed, in order, by pushing their IDs into an order queue. The dispatcher releases the buffer at the head of that queue only after the buffer is complete.

Any buffer can be marked urgent. When the last expected packet of an urgent buffer arrives, the hardware places its ID in a separate urgent queue. The dispatcher always empties the urgent queue before it looks at the software order. An urgent buffer that has already been served is dropped silently when its ID later reaches the head of the software order.

Each phase ends with a phase clear. It wipes the counters, both queues and the record of served buffers, and keeps the programmed targets and urgent marks.

Top module: `buf_sched`

## Requirements
- R1: After rst_ni is released, disp_valid_o and ovf_err_o are 0. No ID is offered until an ID has been pushed into the order queue or an urgent buffer has completed.
- R2: A buffer is complete once the number of arrivals since the last phase clear equals its programmed 8-bit target. The ID at the head of the order queue is offered on disp_id_o only while that buffer is complete. disp_valid_o rises in the cycle after the clock edge that accepts the completing arrival.
- R3: An arrival for a buffer that is already complete leaves its counter unchanged and sets ovf_err_o from the next cycle on. ovf_err_o stays at 1 through phase clears until rst_ni is asserted.
- R4: An urgent buffer (cfg_prio_i=1 when it was programmed) is queued as urgent at the edge that accepts its completing arrival. From the next cycle on, it is offered ahead of a complete buffer at the head of the order queue.
- R5: Several urgent buffers are offered in the order in which they completed, whatever their order in the software queue.
- R6: Each buffer is handed over at most once per phase. An ID at the head of the order queue whose buffer has already been handed over is discarded without being offered.
- R7: A buffer is handed over only in a cycle where disp_valid_o and disp_ready_i are both 1, and at most one is handed over per cycle. While disp_ready_i is 0, disp_valid_o stays at 1 and nothing is lost.
- R8: A cycle with phase_clr_i=1 empties both queues and clears all counters and served flags. disp_valid_o is 0 in the following cycle. The programmed targets and urgent marks are kept.
- R9: A buffer whose target is 0 is complete from the start of the phase. It is never queued as urgent and is handed over only through the order queue.
- R10: Buffers that are not urgent are handed over in the order in which their IDs were pushed into the order queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_clr_i | input | 1 | Synchronous phase clear |
| cfg_we_i | input | 1 | Writes a buffer's target count and urgent mark |
| cfg_id_i | input | 5 | Buffer being programmed |
| cfg_expect_i | input | 8 | Target packet count |
| cfg_prio_i | input | 1 | Urgent mark |
| arr_valid_i | input | 1 | One packet arrived |
| arr_id_i | input | 5 | Buffer that receives the packet |
| ord_push_i | input | 1 | Pushes an ID into the software order queue |
| ord_id_i | input | 5 | ID to push |
| disp_valid_o | output | 1 | A buffer ID is offered |
| disp_ready_i | input | 1 | Consumer accepts the offered ID |
| disp_id_o | output | 5 | Offered buffer ID |
| ovf_err_o | output | 1 | Sticky extra-arrival error |

## Verification
The hardest case to reach is an urgent buffer that completes while the consumer is stalled and a complete ordinary buffer is already offered at the head of the software order. The offer has to switch to the urgent buffer, and the ordinary buffer must still follow afterwards. The stimulus creates this by holding disp_ready_i low and completing the ordinary buffer first. It then completes two urgent buffers in an order opposite to their software order. Only then does it release ready, so the hand-over sequence tests priority and completion order together. The same urgent IDs then come up again at the head of the software order, which tests that served buffers are discarded.

// File: rtl/buf_sched_pkg.sv
package buf_sched_pkg;
  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_HP,
    SRC_ORD,
    SRC_SKIP
  } disp_src_e;
endpackage

// File: rtl/bs_fifo.sv
module bs_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wr_q, rd_q;
  logic         full, do_push, do_pop;

  assign empty_o = (wr_q == rd_q);
  assign full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign do_push = push_i && !full && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign dout_o  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (clr_i) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q[AW-1:0]] <= din_i;
  end
endmodule

// File: rtl/bs_tracker.sv
module bs_tracker #(
  parameter int NB  = 32,
  parameter int CW  = 8,
  parameter int IDW = $clog2(NB)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           cfg_we_i,
  input  logic [IDW-1:0] cfg_id_i,
  input  logic [CW-1:0]  cfg_expect_i,
  input  logic           cfg_prio_i,
  input  logic           arr_valid_i,
  input  logic [IDW-1:0] arr_id_i,
  output logic [NB-1:0]  complete_o,
  output logic           promote_o,
  output logic [IDW-1:0] promote_id_o,
  output logic           ovf_o
);
  logic [CW-1:0] cnt_q [NB];
  logic [CW-1:0] exp_q [NB];
  logic [NB-1:0] prio_q;
  logic [CW-1:0] cnt_nxt;
  logic          arr_ok, arr_extra;

  for (genvar g = 0; g < NB; g++) begin : g_cmp
    assign complete_o[g] = (cnt_q[g] == exp_q[g]);
  end

  assign arr_ok       = arr_valid_i && !clr_i && !complete_o[arr_id_i];
  assign arr_extra    = arr_valid_i && !clr_i && complete_o[arr_id_i];
  assign cnt_nxt      = cnt_q[arr_id_i] + 1'b1;
  // completing arrival of an urgent buffer
  assign promote_o    = arr_ok && prio_q[arr_id_i] && (cnt_nxt == exp_q[arr_id_i]);
  assign promote_id_o = arr_id_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) cnt_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < NB; i++) cnt_q[i] <= '0;
    end else if (arr_ok) begin
      cnt_q[arr_id_i] <= cnt_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) exp_q[i] <= '0;
      prio_q <= '0;
    end else if (cfg_we_i) begin
      exp_q[cfg_id_i]  <= cfg_expect_i;
      prio_q[cfg_id_i] <= cfg_prio_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_o <= 1'b0;
    else if (arr_extra) ovf_o <= 1'b1;
  end
endmodule

// File: rtl/bs_dispatch.sv
module bs_dispatch
  import buf_sched_pkg::*;
#(
  parameter int NB  = 32,
  parameter int IDW = $clog2(NB)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           hp_empty_i,
  input  logic [IDW-1:0] hp_id_i,
  input  logic           ord_empty_i,
  input  logic [IDW-1:0] ord_id_i,
  input  logic [NB-1:0]  complete_i,
  input  logic           ready_i,
  output logic           valid_o,
  output logic [IDW-1:0] id_o,
  output logic           hp_pop_o,
  output logic           ord_pop_o
);
  disp_src_e     src;
  logic [NB-1:0] done_q;

  always_comb begin
    src = SRC_NONE;
    if (!hp_empty_i)                src = SRC_HP;
    else if (!ord_empty_i) begin
      if (done_q[ord_id_i])         src = SRC_SKIP;
      else if (complete_i[ord_id_i]) src = SRC_ORD;
    end
  end

  assign valid_o   = (src == SRC_HP) || (src == SRC_ORD);
  assign id_o      = (src == SRC_HP) ? hp_id_i : ord_id_i;
  assign hp_pop_o  = (src == SRC_HP) && ready_i;
  assign ord_pop_o = ((src == SRC_ORD) && ready_i) || (src == SRC_SKIP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  done_q <= '0;
    else if (clr_i)               done_q <= '0;
    else if (valid_o && ready_i)  done_q[id_o] <= 1'b1;
  end
endmodule

// File: rtl/buf_sched.sv
module buf_sched #(
  parameter int NUM_BUFS = 32,
  parameter int CNT_W    = 8,
  localparam int IDW     = $clog2(NUM_BUFS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           phase_clr_i,
  input  logic           cfg_we_i,
  input  logic [IDW-1:0] cfg_id_i,
  input  logic [CNT_W-1:0] cfg_expect_i,
  input  logic           cfg_prio_i,
  input  logic           arr_valid_i,
  input  logic [IDW-1:0] arr_id_i,
  input  logic           ord_push_i,
  input  logic [IDW-1:0] ord_id_i,
  output logic           disp_valid_o,
  input  logic           disp_ready_i,
  output logic [IDW-1:0] disp_id_o,
  output logic           ovf_err_o
);
  logic [NUM_BUFS-1:0] trk_complete;
  logic                promote_v;
  logic [IDW-1:0]      promote_id;
  logic                hp_empty, hp_pop, ord_empty, ord_pop;
  logic [IDW-1:0]      hp_head, ord_head;

  bs_tracker #(.NB(NUM_BUFS), .CW(CNT_W)) u_trk (
    .clk_i, .rst_ni, .clr_i(phase_clr_i),
    .cfg_we_i, .cfg_id_i, .cfg_expect_i, .cfg_prio_i,
    .arr_valid_i, .arr_id_i,
    .complete_o(trk_complete), .promote_o(promote_v),
    .promote_id_o(promote_id), .ovf_o(ovf_err_o)
  );

  bs_fifo #(.W(IDW), .DEPTH(NUM_BUFS)) u_hp_q (
    .clk_i, .rst_ni, .clr_i(phase_clr_i),
    .push_i(promote_v), .din_i(promote_id),
    .pop_i(hp_pop), .dout_o(hp_head), .empty_o(hp_empty)
  );

  bs_fifo #(.W(IDW), .DEPTH(NUM_BUFS)) u_ord_q (
    .clk_i, .rst_ni, .clr_i(phase_clr_i),
    .push_i(ord_push_i), .din_i(ord_id_i),
    .pop_i(ord_pop), .dout_o(ord_head), .empty_o(ord_empty)
  );

  bs_dispatch #(.NB(NUM_BUFS)) u_disp (
    .clk_i, .rst_ni, .clr_i(phase_clr_i),
    .hp_empty_i(hp_empty), .hp_id_i(hp_head),
    .ord_empty_i(ord_empty), .ord_id_i(ord_head),
    .complete_i(trk_complete), .ready_i(disp_ready_i),
    .valid_o(disp_valid_o), .id_o(disp_id_o),
    .hp_pop_o(hp_pop), .ord_pop_o(ord_pop)
  );
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int NB  = 32,
  parameter int IDW = $clog2(NB)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           clr_i,
  input logic           valid_i,
  input logic           ready_i,
  input logic [IDW-1:0] id_i,
  input logic           ovf_i,
  input logic [NB-1:0]  complete_i,
  input logic           promote_i
);
  logic [NB-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 seen_q <= '0;
    else if (clr_i)              seen_q <= '0;
    else if (valid_i && ready_i) seen_q[id_i] <= 1'b1;
  end

  AST_DISP_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i && !clr_i) |-> !seen_q[id_i]); // R6
  AST_DISP_COMPLETE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> complete_i[id_i]); // R2
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i); // R3
  AST_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_i); // R8
  AST_PROMOTE_OFFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (promote_i && !clr_i) |=> valid_i); // R4
  AST_HOLD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ready_i && !clr_i) |=> valid_i); // R7
endmodule

bind buf_sched bs_checker #(.NB(NUM_BUFS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(phase_clr_i),
  .valid_i(disp_valid_o), .ready_i(disp_ready_i), .id_i(disp_id_o),
  .ovf_i(ovf_err_o), .complete_i(trk_complete), .promote_i(promote_v)
);

// File: tb/sim_buf_sched.sv
`timescale 1ns/1ps
module sim_buf_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, cfg_we = 1'b0, cfg_prio = 1'b0;
  logic [4:0] cfg_id = '0, arr_id = '0, ord_id = '0;
  logic [7:0] cfg_exp = '0;
  logic       arr_v = 1'b0, ord_push = 1'b0, rdy = 1'b1;
  logic       dv, ovf;
  logic [4:0] did;

  int checks = 0, errs = 0, hs_cnt = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  buf_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .phase_clr_i(clr),
    .cfg_we_i(cfg_we), .cfg_id_i(cfg_id), .cfg_expect_i(cfg_exp), .cfg_prio_i(cfg_prio),
    .arr_valid_i(arr_v), .arr_id_i(arr_id),
    .ord_push_i(ord_push), .ord_id_i(ord_id),
    .disp_valid_o(dv), .disp_ready_i(rdy), .disp_id_o(did), .ovf_err_o(ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compares every hand-over with the scoreboard
  always @(negedge clk) begin
    if (rst_n && dv && rdy && !clr) begin
      hs_cnt++;
      checks++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL unexpected hand-over: actual %0d expected none", did);
      end else begin
        if (did != exp_q[0]) begin
          errs++;
          $display("FAIL %s: actual %0d expected %0d", tag_q[0], did, exp_q[0]);
        end
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic expect_id(input int id, input string tag);
    exp_q.push_back(id);
    tag_q.push_back(tag);
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic cfg(input int id, input int e, input bit p);
    cfg_we = 1; cfg_id = 5'(id); cfg_exp = 8'(e); cfg_prio = p;
    cyc(); cfg_we = 0;
  endtask

  task automatic arrive(input int id);
    arr_v = 1; arr_id = 5'(id); cyc(); arr_v = 0;
  endtask

  task automatic push_ord(input int id);
    ord_push = 1; ord_id = 5'(id); cyc(); ord_push = 0;
  endtask

  task automatic phase_clear();
    clr = 1; cyc(); clr = 0;
  endtask

  task automatic sample(output bit v, output int id, output bit o);
    @(negedge clk); v = dv; id = did; o = ovf;
    cyc();
  endtask

  task automatic drain(input string tag);
    repeat (6) cyc();
    chk({tag, " scoreboard left over"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    bit v, o; int id, h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sample(v, id, o);
    chk("R1 valid after reset", v, 0);
    chk("R1 ovf after reset", o, 0);

    cfg(1, 2, 0); cfg(2, 2, 0); cfg(3, 2, 0);
    cfg(5, 1, 1); cfg(6, 1, 1); cfg(7, 1, 0); cfg(9, 0, 1);
    sample(v, id, o);
    chk("R1 valid with empty order queue", v, 0);

    // R2/R10: head incomplete blocks complete followers
    push_ord(2); push_ord(1); push_ord(3);
    arrive(1); arrive(1); arrive(3); arrive(3); arrive(2);
    sample(v, id, o);
    chk("R2 head incomplete holds back", v, 0);
    expect_id(2, "R10 order 1st"); expect_id(1, "R10 order 2nd"); expect_id(3, "R10 order 3rd");
    arrive(2);
    drain("R10");

    // R3: extra arrival
    arrive(1);
    sample(v, id, o);
    chk("R3 ovf set by extra arrival", o, 1);
    phase_clear();
    sample(v, id, o);
    chk("R8 valid after phase clear", v, 0);
    chk("R3 ovf survives phase clear", o, 1);

    // R8: counters cleared, targets retained, served flags cleared
    push_ord(1);
    arrive(1);
    sample(v, id, o);
    chk("R8 counter cleared, needs two", v, 0);
    expect_id(1, "R8 buffer served again");
    arrive(1);
    drain("R8");

    // R4/R5/R7/R6 with consumer stalled
    phase_clear();
    rdy = 0;
    push_ord(7); push_ord(6); push_ord(5);
    arrive(7);
    sample(v, id, o);
    chk("R7 valid ordinary head", v, 1);
    chk("R2 ordinary head offered", id, 7);
    arrive(5);
    sample(v, id, o);
    chk("R4 urgent pre-empts head", id, 5);
    arrive(6);
    repeat (3) cyc();
    sample(v, id, o);
    chk("R7 valid held while stalled", v, 1);
    chk("R5 first completed stays offered", id, 5);
    h0 = hs_cnt;
    expect_id(5, "R5 urgent first"); expect_id(6, "R5 urgent second"); expect_id(7, "R4 ordinary after urgent");
    rdy = 1;
    drain("R5");
    chk("R6 skipped served urgent ids", hs_cnt - h0, 3);
    sample(v, id, o);
    chk("R6 nothing offered after skips", v, 0);

    // R9: zero target
    phase_clear();
    sample(v, id, o);
    chk("R9 zero target never urgent", v, 0);
    h0 = hs_cnt;
    expect_id(9, "R9 zero target via order");
    push_ord(9);
    drain("R9");
    push_ord(9);
    repeat (4) cyc();
    chk("R6 second push discarded", hs_cnt - h0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule